// File: doc/BRIEF.md
# Linear Time Code Frame Generator

This block serialises linear time code frames onto a single line using biphase-mark encoding. Each 80-bit frame carries 64 data bits, taken from eight host-written bytes, followed by a fixed 16-bit sync word. The host-written bytes are held apart from the output by a shadow buffer. The block copies the bytes into that buffer at well-defined moments and raises a one-cycle pulse each time, so that the host knows it may write the next frame's bytes.

Once enable is raised, the block takes its first copy at once and then waits for an external start pulse before it drives the line. Frames then follow each other with no gap. The copy for each following frame is taken eight bit cells before the end of the frame being sent, which is inside its sync word. The length of half a bit cell is given in clock cycles on an input port.

The data and control inputs are plain register-style levels, not a stream. The host may change them at any time, and the block samples them only at the moments stated below. No valid/ready handshake applies, and no back-pressure exists: the line runs at the programmed rate.

Top module: `ltcg_top`

## Requirements
- R1: After reset, `line_out` is 0, `loaded` is 0 and the block is idle.
- R2: When `enable` is seen high while idle, `frame_data` is copied into the shadow buffer. `loaded` is high for exactly one cycle, on the cycle after that clock edge.
- R3: Before the start pulse, `line_out` does not change. This covers the idle state and the wait that follows enable. A `start_sync` pulse while idle with `enable` low has no effect.
- R4: Every bit cell lasts 2 x `half_len` clock cycles and begins with a line transition. A 1 bit adds a second transition after `half_len` cycles, and a 0 bit does not. A `half_len` of 0 acts as 1.
- R5: A frame sends `frame_data` bit 0 first, up to bit 63, where byte n occupies bits 8n+7:8n. It then sends the sync word 0,0,1,1, then ten 1s, then 0,1, in that time order.
- R6: At the clock edge that starts bit cell 72, if `enable` is high, `frame_data` is copied and `loaded` pulses for one cycle. The next frame then follows the current one with no gap.
- R7: If `enable` is low at the start of bit cell 72, no copy is taken. The frame completes, the block returns to idle, and `line_out` holds its last level.
- R8: Dropping `enable` while waiting for the start pulse returns the block to idle, and a later `start_sync` has no effect.
- R9: Changing `frame_data` while a frame is being sent does not alter that frame's data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Generator enable level |
| start_sync | input | 1 | One-cycle external start event |
| half_len | input | HALF_W | Clock cycles per half bit cell |
| frame_data | input | 64 | Eight host bytes, byte n at bits 8n+7:8n |
| line_out | output | 1 | Biphase-mark encoded serial line |
| loaded | output | 1 | One-cycle pulse when the bytes have been copied |

## Verification
Two events share one clock edge: the reload copy at the start of bit cell 72 and that cell's opening line transition. The host may also change `frame_data` and `enable` at nearby times. The bench rewrites `frame_data` just after a frame starts and drops `enable` partway through the last frame of each run. It then decodes every half cell of the line into bits. It judges the result in three ways: the running frame must still carry the old bytes, the following frame must carry the bytes present at the bit-72 edge, and the `loaded` pulse must appear on exactly the sample after that edge, or not at all when `enable` was already low.

// File: rtl/ltcg_pkg.sv
package ltcg_pkg;
  localparam int DATA_BITS   = 64;
  localparam int SYNC_BITS   = 16;
  localparam int FRAME_BITS  = DATA_BITS + SYNC_BITS;
  localparam int LEAD_BITS   = 8;
  localparam int RELOAD_IDX  = FRAME_BITS - LEAD_BITS;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int DATA_IDX_W  = $clog2(DATA_BITS);
  localparam int SYNC_IDX_W  = $clog2(SYNC_BITS);
  // time order: MSB first
  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 16'b0011_1111_1111_1101;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} ltcg_state_e;
endpackage

// File: rtl/ltcg_half_timer.sv
module ltcg_half_timer #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign tick    = run && (cnt_inc >= {1'b0, half_len});

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ltcg_bit_pick.sv
module ltcg_bit_pick
  import ltcg_pkg::*;
(
  input  logic [DATA_BITS-1:0] shadow,
  input  logic [IDX_W-1:0]     bidx,
  output logic                 cur_bit
);
  always_comb begin
    if (bidx[DATA_IDX_W])
      cur_bit = SYNC_WORD[~bidx[SYNC_IDX_W-1:0]];
    else
      cur_bit = shadow[bidx[DATA_IDX_W-1:0]];
  end
endmodule

// File: rtl/ltcg_frame_ctrl.sv
module ltcg_frame_ctrl
  import ltcg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 start_sync,
  input  logic [DATA_BITS-1:0] frame_data,
  input  logic                 tick,
  input  logic                 cur_bit,
  output ltcg_state_e          st,
  output logic [IDX_W-1:0]     bidx,
  output logic [DATA_BITS-1:0] shadow,
  output logic                 loaded,
  output logic                 cell_start,
  output logic                 mid_flip
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] LOAD_IDX = IDX_W'(RELOAD_IDX);

  logic second_half;
  logic keep_going;

  assign cell_start = (st == ST_WAIT && enable && start_sync) ||
                      (st == ST_RUN && tick && second_half &&
                       (bidx != LAST_IDX || keep_going));
  assign mid_flip   = st == ST_RUN && tick && !second_half && cur_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bidx        <= '0;
      shadow      <= '0;
      loaded      <= 1'b0;
      second_half <= 1'b0;
      keep_going  <= 1'b0;
    end else begin
      loaded <= 1'b0;
      unique case (st)
        ST_IDLE: if (enable) begin
          shadow <= frame_data;
          loaded <= 1'b1;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!enable) st <= ST_IDLE;
          else if (start_sync) begin
            st          <= ST_RUN;
            bidx        <= '0;
            second_half <= 1'b0;
            keep_going  <= 1'b0;
          end
        end
        ST_RUN: if (tick) begin
          if (!second_half) second_half <= 1'b1;
          else begin
            second_half <= 1'b0;
            if (bidx == LAST_IDX) begin
              if (keep_going) bidx <= '0;
              else            st   <= ST_IDLE;
            end else begin
              bidx <= bidx + 1'b1;
              if (bidx + 1'b1 == LOAD_IDX) begin
                keep_going <= enable;
                if (enable) begin
                  shadow <= frame_data;
                  loaded <= 1'b1;
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_loaded_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> !loaded);

  assert_reload_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && st == ST_RUN) |-> (bidx == LOAD_IDX && !second_half));
endmodule

// File: rtl/ltcg_bmc_line.sv
module ltcg_bmc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic mid_flip,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     line <= 1'b0;
    else if (cell_start || mid_flip) line <= ~line;
  end

  assert_one_edge_per_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_start && mid_flip));
endmodule

// File: rtl/ltcg_top.sv
module ltcg_top
  import ltcg_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 start_sync,
  input  logic [HALF_W-1:0]    half_len,
  input  logic [DATA_BITS-1:0] frame_data,
  output logic                 line_out,
  output logic                 loaded
);
  ltcg_state_e          st;
  logic [IDX_W-1:0]     bidx;
  logic [DATA_BITS-1:0] shadow;
  logic                 tick, cur_bit, cell_start, mid_flip;

  ltcg_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == ST_RUN), .half_len(half_len), .tick(tick)
  );

  ltcg_bit_pick u_pick (.shadow(shadow), .bidx(bidx), .cur_bit(cur_bit));

  ltcg_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_sync(start_sync),
    .frame_data(frame_data), .tick(tick), .cur_bit(cur_bit), .st(st),
    .bidx(bidx), .shadow(shadow), .loaded(loaded),
    .cell_start(cell_start), .mid_flip(mid_flip)
  );

  ltcg_bmc_line u_line (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .mid_flip(mid_flip), .line(line_out)
  );

  assert_idle_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> $stable(line_out));

  assert_wait_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !start_sync) |=> $stable(line_out));
endmodule

// File: tb/ltcg_top_bench.sv
module ltcg_top_bench;
  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start_sync = 1'b0;
  logic [15:0] half_len = 16'd3;
  logic [63:0] frame_data = '0;
  logic        line_out, loaded;

  localparam logic [15:0] SYNC_EXP = 16'b0011_1111_1111_1101;

  int checks = 0, fails = 0, lcnt = 0;
  bit done = 1'b0;
  logic [63:0] armed = '0;

  always #5 clk = ~clk;

  ltcg_top u_ltcg_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_sync(start_sync),
    .half_len(half_len), .frame_data(frame_data), .line_out(line_out), .loaded(loaded)
  );

  always @(negedge clk) if (loaded === 1'b1) lcnt++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sync_order(input logic [79:0] bits);
    logic [15:0] s;
    for (int k = 0; k < 16; k++) s[15-k] = bits[64+k];
    return s;
  endfunction

  task automatic arm(input logic [63:0] d);
    frame_data = d;
    enable = 1'b1;
    @(negedge clk);
    check(loaded === 1'b1, "R2 loaded after enable", {63'd0, loaded}, 64'd1);
    @(negedge clk);
    check(loaded === 1'b0, "R2 loaded one cycle", {63'd0, loaded}, 64'd0);
    armed = d;
  endtask

  task automatic hold_check(input int n, input logic lvl, input int lc, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_out !== lvl) ok = 1'b0;
    end
    check(ok && lcnt == lc, req, {63'd0, line_out}, {63'd0, lvl});
  endtask

  task automatic run_frames(input int h, input int nframes, input logic [63:0] nd);
    logic prev;
    logic [63:0] cur, nxt;
    logic [159:0] hv;
    logic [79:0] bits;
    bit tr_ok;
    int l0;
    half_len = 16'(h);
    prev = line_out;
    cur = armed;
    nxt = armed;
    l0 = lcnt;
    start_sync = 1'b1;
    for (int f = 0; f < nframes; f++) begin
      for (int j = 0; j < 160; j++) begin
        if (f == 0 && j == 0) begin
          @(negedge clk);
          start_sync = 1'b0;
        end else repeat ((h < 1) ? 1 : h) @(negedge clk);
        hv[j] = line_out;
        if (f == 0 && j == 2) frame_data = nd;
        if (j == 144) begin
          check(loaded === (f < nframes - 1), "R6 reload pulse at bit 72",
                {63'd0, loaded}, {63'd0, f < nframes - 1});
          nxt = frame_data;
        end
        if (f == nframes - 1 && j == 100) enable = 1'b0;
      end
      tr_ok = 1'b1;
      for (int k = 0; k < 80; k++) begin
        bits[k] = hv[2*k] ^ hv[2*k+1];
        if (hv[2*k] == ((k == 0) ? prev : hv[2*k-1])) tr_ok = 1'b0;
      end
      check(tr_ok, "R4 cell start transitions", {63'd0, tr_ok}, 64'd1);
      check(bits[63:0] == cur, (f == 0) ? "R9 R5 data bits kept" : "R5 R6 data bits",
            bits[63:0], cur);
      check(sync_order(bits) == SYNC_EXP, "R5 sync word", {48'd0, sync_order(bits)},
            {48'd0, SYNC_EXP});
      prev = hv[159];
      cur = nxt;
    end
    check(lcnt - l0 == nframes - 1, "R6 reload count", 64'(lcnt - l0), 64'(nframes - 1));
    hold_check(6 * h + 12, prev, lcnt, "R7 idle after stop");
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(line_out === 1'b0, "R1 line reset", {63'd0, line_out}, 64'd0);
    check(loaded === 1'b0, "R1 loaded reset", {63'd0, loaded}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: start pulse while idle
    start_sync = 1'b1;
    @(negedge clk);
    start_sync = 1'b0;
    hold_check(20, 1'b0, 0, "R3 idle ignores start");
    // R8: drop enable while waiting
    arm(64'hA5A5_0F0F_1234_5678);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    start_sync = 1'b1;
    @(negedge clk);
    start_sync = 1'b0;
    hold_check(20, 1'b0, 1, "R8 wait abandoned");
    // directed three back-to-back frames
    arm(64'h0123_4567_89AB_CDEF);
    hold_check(7, 1'b0, 2, "R3 wait silent");
    run_frames(3, 3, 64'hFFFF_0000_F0F0_8001);
    // shortest cell
    arm(64'h8000_0000_0000_0001);
    run_frames(1, 2, 64'h5555_AAAA_0000_FFFF);
    // half_len 0 acts as 1
    arm(64'hDEAD_BEEF_CAFE_F00D);
    run_frames(0, 1, 64'h0);
    // random frames
    for (int it = 0; it < 5; it++) begin
      logic [63:0] d1, d2;
      int h, nf, w;
      d1 = {$urandom, $urandom};
      d2 = {$urandom, $urandom};
      h  = 1 + int'($urandom % 4);
      nf = 1 + int'($urandom % 2);
      w  = int'($urandom % 10);
      arm(d1);
      repeat (w) @(negedge clk);
      run_frames(h, nf, d2);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule